// File: doc/BRIEF.md
# Event Interrupt Coalescer

This block gathers event pulses from a device into a sticky status register, filters them through a mask, and drives one interrupt line toward a CPU. A holdoff timer groups bursts of events into one interrupt. The holdoff is a programmable number of clock cycles, and some event classes skip it. A deadline that is already running is never pushed later. A deadline that fires while the line is still high and unacknowledged adds nothing new.

Software uses a small register port with four registers. Select 0 is status. Writing it clears each bit written as one. Reading it with the read strobe lowers the line and leaves the status bits unchanged. Select 1 is the mask. Select 2 is control, where bit 0 is the global enable. Select 3 is the command register, where writing bit 0 as one posts a software event; it reads as zero.

Two watermark events have hysteresis. They can raise the line only after their queue has reported the opposite extreme. Event bit positions are: receive-packet 0, receive-high 1, receive-empty 2, receive-copy-done 3, transmit-packet 4, transmit-low 5, transmit-full 6, transmit-copy-done 7, software 8. Bits 9 and above are reserved.

Top module: `evt_irq_coalescer`

## Requirements
- R1: After reset, status reads 0, mask reads 0x123 (software, receive-high, receive-packet, transmit-low), control reads 0, and irq and access_err are low.
- R2: Posted event bits are ORed into status at the next edge. A status write clears the bits written as one, and a post of the same bit in the same cycle wins over the clear. Reserved bits (9 and up) are never set, and posting or clearing one makes access_err high for exactly the cycle after that edge.
- R3: With enable (control bit 0) clear, no deadline is scheduled. Clearing enable cancels a running deadline.
- R4: A post whose masked, unblocked pending bits are all outside the no-delay group raises irq holdoff+1 edges after the posting edge.
- R5: If any masked, unblocked pending bit is in the no-delay group (software bit 8, receive-high bit 1, transmit-low bit 5), irq rises one edge after the posting edge.
- R6: A later request never moves a running deadline later. A request that would expire sooner replaces the running deadline.
- R7: A deadline that expires while irq is already high raises nothing new. After that irq is dropped, it stays low.
- R8: When status AND mask becomes zero, irq drops at that same edge and any running deadline is cancelled.
- R9: A status read with reg_rd, or irq_ack, lowers irq at the next edge and leaves status unchanged.
- R10: Setting enable, or writing a different mask, while status AND the new mask is nonzero raises irq one edge later.
- R11: Writing command bit 0 as one sets status bit 8. Writing it as zero changes nothing.
- R12: Receive-high (bit 1) takes part in scheduling only once rx_empty has been high at some edge since the last receive-high post.
- R13: Transmit-low (bit 5) takes part in scheduling only once tx_full has been high at some edge since the last transmit-low post.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_post | input | EVW | Event pulses to OR into status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on status read) |
| reg_sel | input | 2 | Register select: 0 status, 1 mask, 2 control, 3 command |
| reg_wdata | input | EVW | Register write data |
| reg_rdata | output | EVW | Register read data, combinational from reg_sel |
| holdoff | input | DLYW | Holdoff delay in clock cycles |
| rx_empty | input | 1 | Receive queue is empty (arms receive-high) |
| tx_full | input | 1 | Transmit queue is full (arms transmit-low) |
| irq_ack | input | 1 | CPU acknowledge, lowers the line |
| irq | output | 1 | Interrupt line to the CPU |
| access_err | output | 1 | Pulse: a reserved bit was posted or cleared |

## Verification
A wrong deadline counter shows up as irq rising early or late against holdoff+1. Directed posts with known holdoff values catch that at the exact edge. A lost or stuck hysteresis arm shows as irq rising, or failing to rise, within a few cycles of a watermark post. A status register that has drifted from the expected OR/clear history is caught on the next readback, because every random cycle compares status and access_err. A line that fails to drop, or a deadline that survives cancellation, stays visible at irq during a multi-cycle quiet window after the clearing write or the acknowledge.

// File: rtl/eic_pkg.sv
package eic_pkg;
   // event bit positions; the no-delay and default-mask sets depend on them
   localparam int EV_RX_PKT   = 0;
   localparam int EV_RX_HIGH  = 1;
   localparam int EV_RX_EMPTY = 2;
   localparam int EV_RX_DMA   = 3;
   localparam int EV_TX_PKT   = 4;
   localparam int EV_TX_LOW   = 5;
   localparam int EV_TX_FULL  = 6;
   localparam int EV_TX_DMA   = 7;
   localparam int EV_SOFT     = 8;
   localparam int EV_DEFINED  = 9;

   localparam logic [31:0] DEFINED_MASK = (32'd1 << EV_DEFINED) - 32'd1;
   localparam logic [31:0] DEF_MASK     = (32'd1 << EV_SOFT) | (32'd1 << EV_RX_HIGH)
                                        | (32'd1 << EV_RX_PKT) | (32'd1 << EV_TX_LOW);
   localparam logic [31:0] NODELAY_MASK = (32'd1 << EV_SOFT) | (32'd1 << EV_RX_HIGH)
                                        | (32'd1 << EV_TX_LOW);

   localparam int NUM_WM = 2;

   typedef enum logic [1:0] {
      SEL_STATUS = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_CMD    = 2'd3
   } reg_sel_e;

   // watermark channel -> event bit it gates
   function automatic int wm_bit(input int ch);
      return (ch == 0) ? EV_RX_HIGH : EV_TX_LOW;
   endfunction
endpackage

// File: rtl/eic_wm_gate.sv
module eic_wm_gate
   import eic_pkg::*;
#(
   parameter int EVW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_WM-1:0] wm_level,
   input  logic [EVW-1:0]    post_ok,
   output logic [EVW-1:0]    block
);
   logic [NUM_WM-1:0] arm_w;

   for (genvar i = 0; i < NUM_WM; i++) begin : g_arm
      localparam int B = wm_bit(i);
      logic arm_q;
      always_ff @(posedge clk) begin
         if (!rst_n) arm_q <= 1'b0;
         else        arm_q <= wm_level[i] | (arm_q & ~post_ok[B]);
      end
      assign arm_w[i] = arm_q;
   end

   always_comb begin
      block = '0;
      for (int i = 0; i < NUM_WM; i++) block[wm_bit(i)] = ~arm_w[i];
   end
endmodule

// File: rtl/eic_status_bank.sv
module eic_status_bank
   import eic_pkg::*;
#(
   parameter int EVW  = 16,
   parameter int DLYW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EVW-1:0]  evt_post,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [1:0]      reg_sel,
   input  logic [EVW-1:0]  reg_wdata,
   input  logic [DLYW-1:0] holdoff,
   input  logic [EVW-1:0]  wm_block,
   output logic [EVW-1:0]  post_ok,
   output logic [EVW-1:0]  status_q,
   output logic [EVW-1:0]  mask_q,
   output logic            en_q,
   output logic            req,
   output logic [DLYW-1:0] req_dly,
   output logic            cancel,
   output logic            pend_zero,
   output logic            rd_status,
   output logic            err_q
);
   localparam logic [EVW-1:0] RSVD   = ~DEFINED_MASK[EVW-1:0];
   localparam logic [EVW-1:0] SOFT_V = EVW'(1) << EV_SOFT;
   localparam logic [EVW-1:0] NODLY  = NODELAY_MASK[EVW-1:0];
   localparam logic [EVW-1:0] RST_MK = DEF_MASK[EVW-1:0];

   logic           wr_status, wr_mask, wr_ctrl, wr_cmd;
   logic [EVW-1:0] raw_post, raw_clr, clr_ok;
   logic [EVW-1:0] status_n, mask_n, pend_n, gated;
   logic           en_n, bad, post_req, now_req, urgent;

   always_comb begin
      wr_status = reg_wr && (reg_sel == SEL_STATUS);
      wr_mask   = reg_wr && (reg_sel == SEL_MASK);
      wr_ctrl   = reg_wr && (reg_sel == SEL_CTRL);
      wr_cmd    = reg_wr && (reg_sel == SEL_CMD);
      rd_status = reg_rd && (reg_sel == SEL_STATUS);

      raw_post = evt_post | ((wr_cmd && reg_wdata[0]) ? SOFT_V : '0);
      raw_clr  = wr_status ? reg_wdata : '0;
      post_ok  = raw_post & ~RSVD;
      clr_ok   = raw_clr & ~RSVD;
      bad      = (|(raw_post & RSVD)) || (|(raw_clr & RSVD));

      status_n = (status_q & ~clr_ok) | post_ok;
      mask_n   = wr_mask ? (reg_wdata & ~RSVD) : mask_q;
      en_n     = wr_ctrl ? reg_wdata[0] : en_q;
      pend_n   = status_n & mask_n;
      gated    = pend_n & ~wm_block;

      post_req  = (|post_ok) && (|gated);
      now_req   = ((mask_n != mask_q) || (en_n && !en_q)) && (|pend_n);
      req       = en_n && (post_req || now_req);
      urgent    = now_req || (|(gated & NODLY));
      req_dly   = urgent ? '0 : holdoff;
      pend_zero = ~(|pend_n);
      cancel    = !en_n || pend_zero;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         mask_q   <= RST_MK;
         en_q     <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         status_q <= status_n;
         mask_q   <= mask_n;
         en_q     <= en_n;
         err_q    <= bad;
      end
   end
endmodule

// File: rtl/eic_deadline_timer.sv
module eic_deadline_timer #(
   parameter int DLYW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic [DLYW-1:0] req_dly,
   input  logic            cancel,
   output logic            fire,
   output logic            active_q
);
   logic [DLYW-1:0] cnt_q;

   assign fire = active_q && (cnt_q == '0) && !cancel;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (cancel) begin
         active_q <= 1'b0;
      end else if (req && (!active_q || (req_dly < cnt_q))) begin
         active_q <= 1'b1;
         cnt_q    <= req_dly;
      end else if (active_q) begin
         if (cnt_q == '0) active_q <= 1'b0;
         else             cnt_q    <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/eic_line_ctl.sv
module eic_line_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic drop,
   output logic irq_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    irq_q <= 1'b0;
      else if (drop) irq_q <= 1'b0;
      else if (fire) irq_q <= 1'b1;
   end
endmodule

// File: rtl/evt_irq_coalescer.sv
module evt_irq_coalescer
   import eic_pkg::*;
#(
   parameter int EVW  = 16,
   parameter int DLYW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [EVW-1:0]  evt_post,
   input  logic            reg_wr,
   input  logic            reg_rd,
   input  logic [1:0]      reg_sel,
   input  logic [EVW-1:0]  reg_wdata,
   output logic [EVW-1:0]  reg_rdata,
   input  logic [DLYW-1:0] holdoff,
   input  logic            rx_empty,
   input  logic            tx_full,
   input  logic            irq_ack,
   output logic            irq,
   output logic            access_err
);
   if (EVW < EV_DEFINED || EVW > 32) begin : g_bad_evw
      initial $error("evt_irq_coalescer: EVW must lie in [9,32]");
   end
   if (DLYW < 1 || DLYW > 31) begin : g_bad_dlyw
      initial $error("evt_irq_coalescer: DLYW must lie in [1,31]");
   end

   logic [EVW-1:0]  post_ok, status_q, mask_q, wm_block;
   logic            en_q, req, cancel, pend_zero, rd_status, fire, tmr_active;
   logic [DLYW-1:0] req_dly;

   eic_wm_gate #(.EVW(EVW)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .wm_level ({tx_full, rx_empty}),
      .post_ok  (post_ok),
      .block    (wm_block)
   );

   eic_status_bank #(.EVW(EVW), .DLYW(DLYW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_post  (evt_post),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .holdoff   (holdoff),
      .wm_block  (wm_block),
      .post_ok   (post_ok),
      .status_q  (status_q),
      .mask_q    (mask_q),
      .en_q      (en_q),
      .req       (req),
      .req_dly   (req_dly),
      .cancel    (cancel),
      .pend_zero (pend_zero),
      .rd_status (rd_status),
      .err_q     (access_err)
   );

   eic_deadline_timer #(.DLYW(DLYW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_dly  (req_dly),
      .cancel   (cancel),
      .fire     (fire),
      .active_q (tmr_active)
   );

   eic_line_ctl u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (fire),
      .drop  (pend_zero || rd_status || irq_ack),
      .irq_q (irq)
   );

   always_comb begin
      unique case (reg_sel)
         SEL_STATUS: reg_rdata = status_q;
         SEL_MASK:   reg_rdata = mask_q;
         SEL_CTRL:   reg_rdata = {{(EVW-1){1'b0}}, en_q};
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/eic_checker.sv
module eic_checker
   import eic_pkg::*;
#(
   parameter int EVW = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           irq,
   input logic           irq_ack,
   input logic [EVW-1:0] status,
   input logic [EVW-1:0] mask,
   input logic           en,
   input logic           tmr_active,
   input logic           fire
);
   localparam logic [EVW-1:0] RSVD = ~DEFINED_MASK[EVW-1:0];

   assert_line_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status & mask) == '0) |-> !irq);

   assert_rsvd_never_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (status & RSVD) == '0);

   assert_ack_drops_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !irq);

   assert_disabled_no_deadline_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !tmr_active);

   assert_rise_from_deadline_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(fire));
endmodule

bind evt_irq_coalescer eic_checker #(.EVW(EVW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq        (irq),
   .irq_ack    (irq_ack),
   .status     (status_q),
   .mask       (mask_q),
   .en         (en_q),
   .tmr_active (tmr_active),
   .fire       (fire)
);

// File: tb/evt_irq_coalescer_test.sv
module evt_irq_coalescer_test;
   localparam int EVW  = 16;
   localparam int DLYW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [EVW-1:0]  evt_post = '0;
   logic            reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]      reg_sel = 2'd0;
   logic [EVW-1:0]  reg_wdata = '0;
   logic [EVW-1:0]  reg_rdata;
   logic [DLYW-1:0] holdoff = '0;
   logic            rx_empty = 1'b0, tx_full = 1'b0, irq_ack = 1'b0;
   logic            irq, access_err;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   evt_irq_coalescer #(.EVW(EVW), .DLYW(DLYW)) uut (
      .clk(clk), .rst_n(rst_n), .evt_post(evt_post), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .holdoff(holdoff),
      .rx_empty(rx_empty), .tx_full(tx_full), .irq_ack(irq_ack), .irq(irq),
      .access_err(access_err)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [EVW-1:0] peek(input logic [1:0] s);
      return (s == 2'd0) ? uut.reg_rdata : '0;
   endfunction

   task automatic rd_reg(input logic [1:0] s, output logic [EVW-1:0] v);
      reg_sel = s;
      #1;
      v = reg_rdata;
   endtask

   task automatic wr(input logic [1:0] s, input logic [EVW-1:0] d);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      cyc(1);
      reg_wr = 1'b0;
   endtask

   task automatic post(input logic [EVW-1:0] v);
      evt_post = v;
      cyc(1);
      evt_post = '0;
   endtask

   task automatic clean();
      reg_sel = 2'd0; reg_wdata = 16'h01FF; reg_wr = 1'b1; irq_ack = 1'b1;
      cyc(1);
      reg_wr = 1'b0; irq_ack = 1'b0;
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   function automatic logic [EVW-1:0] model_status(input logic [EVW-1:0] s,
         input logic [EVW-1:0] p, input logic [EVW-1:0] c);
      return (s & ~(c & 16'h01FF)) | (p & 16'h01FF);
   endfunction

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [EVW-1:0] v;
      logic [EVW-1:0] exp_s;
      void'($urandom(32'd4242));
      cyc(3);
      rst_n = 1'b1;
      cyc(1);

      // R1 reset values
      chk(irq, 0, "R1 irq");
      chk(access_err, 0, "R1 err");
      rd_reg(2'd0, v); chk(v, 16'h0000, "R1 status");
      rd_reg(2'd1, v); chk(v, 16'h0123, "R1 mask");
      rd_reg(2'd2, v); chk(v, 16'h0000, "R1 ctrl");

      // R3 disabled: nothing scheduled
      holdoff = 8'd2;
      post(16'h0001);
      cyc(8);
      chk(irq, 0, "R3 disabled no irq");
      rd_reg(2'd0, v); chk(v, 16'h0001, "R2 post sets status");

      // R10 enable with pending -> one edge
      wr(2'd2, 16'h0001);
      chk(irq, 0, "R10 enable not yet");
      cyc(1);
      chk(irq, 1, "R10 enable raises");

      // R9 read drops line, status kept
      reg_sel = 2'd0; reg_rd = 1'b1; cyc(1); reg_rd = 1'b0;
      chk(irq, 0, "R9 read drops");
      rd_reg(2'd0, v); chk(v, 16'h0001, "R9 status kept");
      cyc(6);
      chk(irq, 0, "R9 stays low");

      // R2 W1C and post-over-clear
      wr(2'd0, 16'h0000);
      rd_reg(2'd0, v); chk(v, 16'h0001, "R2 zero write keeps");
      wr(2'd0, 16'h0001);
      rd_reg(2'd0, v); chk(v, 16'h0000, "R2 w1c clears");
      evt_post = 16'h0010; reg_sel = 2'd0; reg_wdata = 16'h0010; reg_wr = 1'b1;
      cyc(1); evt_post = '0; reg_wr = 1'b0;
      rd_reg(2'd0, v); chk(v, 16'h0010, "R2 post wins over clear");
      clean();

      // R4 holdoff delay
      holdoff = 8'd4;
      post(16'h0001);
      cyc(4); chk(irq, 0, "R4 before holdoff");
      cyc(1); chk(irq, 1, "R4 at holdoff+1");
      clean();

      // R11 / R5 software command bypasses holdoff
      wr(2'd3, 16'h0000);
      rd_reg(2'd0, v); chk(v, 16'h0000, "R11 zero command");
      wr(2'd3, 16'h0001);
      rd_reg(2'd0, v); chk(v, 16'h0100, "R11 soft bit set");
      cyc(1); chk(irq, 1, "R5 no-delay raise");
      rd_reg(2'd3, v); chk(v, 16'h0000, "R11 command reads zero");
      clean();

      // R6 later request does not postpone
      holdoff = 8'd10;
      post(16'h0001);
      cyc(3);
      holdoff = 8'd20;
      post(16'h0001);
      cyc(6); chk(irq, 0, "R6 not yet");
      cyc(1); chk(irq, 1, "R6 original deadline kept");
      clean();

      // R6 sooner request replaces
      holdoff = 8'd10;
      post(16'h0001);
      holdoff = 8'd2;
      post(16'h0001);
      cyc(2); chk(irq, 0, "R6 sooner not yet");
      cyc(1); chk(irq, 1, "R6 sooner wins");
      clean();

      // R7 deadline while high adds nothing
      holdoff = 8'd3;
      post(16'h0001);
      cyc(4); chk(irq, 1, "R7 first raise");
      post(16'h0001);
      cyc(6); chk(irq, 1, "R7 still high");
      irq_ack = 1'b1; cyc(1); irq_ack = 1'b0;
      chk(irq, 0, "R9 ack drops");
      cyc(8); chk(irq, 0, "R7 no re-raise");
      clean();

      // R10 mask change, R8 drop on zero
      post(16'h0010);
      cyc(6); chk(irq, 0, "R10 unmasked quiet");
      wr(2'd1, 16'h0133);
      cyc(1); chk(irq, 1, "R10 mask raise");
      wr(2'd1, 16'h0123);
      chk(irq, 0, "R8 mask to zero drops");
      clean();

      // R12 receive-high hysteresis
      holdoff = 8'd2;
      post(16'h0002);
      cyc(8); chk(irq, 0, "R12 unarmed blocked");
      clean();
      rx_empty = 1'b1; cyc(1); rx_empty = 1'b0;
      post(16'h0002);
      cyc(1); chk(irq, 1, "R12 armed raise");
      clean();
      post(16'h0002);
      cyc(8); chk(irq, 0, "R12 arm consumed");
      clean();

      // R13 transmit-low hysteresis
      post(16'h0020);
      cyc(8); chk(irq, 0, "R13 unarmed blocked");
      clean();
      tx_full = 1'b1; cyc(1); tx_full = 1'b0;
      post(16'h0020);
      cyc(1); chk(irq, 1, "R13 armed raise");
      clean();
      post(16'h0020);
      cyc(8); chk(irq, 0, "R13 arm consumed");
      clean();

      // R8 clearing cancels deadline
      holdoff = 8'd6;
      post(16'h0001);
      cyc(2);
      wr(2'd0, 16'h0001);
      cyc(10); chk(irq, 0, "R8 deadline cancelled");

      // R3 disabling cancels deadline
      post(16'h0001);
      cyc(2);
      wr(2'd2, 16'h0000);
      cyc(10); chk(irq, 0, "R3 disable cancels");
      wr(2'd2, 16'h0001);
      cyc(1); chk(irq, 1, "R10 re-enable raises");
      clean();

      // R2 reserved bits
      post(16'h1000);
      chk(access_err, 1, "R2 reserved post err");
      rd_reg(2'd0, v); chk(v, 16'h0000, "R2 reserved not set");
      cyc(1); chk(access_err, 0, "R2 err one cycle");
      wr(2'd0, 16'h0200);
      chk(access_err, 1, "R2 reserved clear err");
      cyc(1);

      // random phase: status history and error flag
      rd_reg(2'd0, exp_s);
      for (int i = 0; i < 300; i++) begin
         logic [EVW-1:0] p, c;
         logic do_clr, e_err;
         p = EVW'($urandom & 32'h00FF);
         if (($urandom % 10) == 0) p = p | EVW'(32'h1 << (9 + ($urandom % 7)));
         do_clr = (($urandom % 4) == 0);
         c = do_clr ? EVW'($urandom) : '0;
         if (do_clr && (($urandom % 3) != 0)) c = c & 16'h01FF;
         e_err = (|(p & 16'hFE00)) || (|(c & 16'hFE00));
         evt_post = p; reg_sel = 2'd0; reg_wdata = c; reg_wr = do_clr;
         cyc(1);
         evt_post = '0; reg_wr = 1'b0;
         exp_s = model_status(exp_s, p, c);
         rd_reg(2'd0, v); chk(v, exp_s, "R2 random status");
         chk(access_err, e_err, "R2 random err");
      end

      done = 1;
      summary();
      $finish;
   end
endmodule